// File: doc/BRIEF.md
# Millisecond-Tick Watchdog Timer

This block is a watchdog peripheral that sits on a simple 32-bit register bus. The bus has a write strobe, a read strobe, a byte address and write data. A programmable prescaler divides the input clock into a slow tick. Software normally programs the divide value so that one tick lasts one millisecond. A 16-bit tick counter counts up toward a programmed terminal value. When the counter reaches that value, the block can issue a one-cycle system reset request.

Software first programs the terminal value and the divide value. It then sets the run and reset-enable controls. After that it refreshes the timer by writing anything to a dedicated restart register. One read of the count register returns both the terminal value and the live count, so software can work out the time left as terminal minus count. Clearing the run bit freezes the count and rewinds the prescaler phase.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, every register reads zero and `wdt_rst_req` is low.
- R2: The control register is at offset 0x00 and is fully rewritten by each write. It stores only these fields: divide value in bits 17:0, run in bit 18, reset-enable in bit 21, clock-enable in bit 24 and divider-enable in bit 25. All other bits read back as zero.
- R3: The prescaler advances only while run, clock-enable and divider-enable are all 1. In that state it gives one tick every D advancing cycles, where D is the divide value and a D of 0 acts as 1. Each tick adds one to the count.
- R4: While run is 0 the count holds its value. Clearing run also returns the prescaler phase to zero, so after run is set again the first tick needs a full D cycles.
- R5: The count register is at offset 0x08. Bits 15:0 hold the terminal value and can be read and written. Bits 31:16 return the live count and ignore writes. A write of the terminal value leaves the live count unchanged.
- R6: Any write to offset 0x0C clears the count to zero, whatever the data. That offset reads as zero. A clear in the same cycle as a tick wins over the increment.
- R7: When a tick brings the count up to the terminal value while reset-enable is 1, `wdt_rst_req` is high for exactly one cycle, starting at the clock edge where the count reaches the terminal value. After that the count holds at the terminal value.
- R8: When reset-enable is 0, reaching the terminal value raises no reset request. The count still stops at the terminal value.
- R9: Reads of offsets other than 0x00, 0x08 and 0x0C return zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is strobed |
| wdt_rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The bench builds the block with its default widths: an 18-bit divide value, a 16-bit counter and an 8-bit offset. It programs divide values of 0 to 4 at run time, so ticks come within a few cycles. Small terminal values then bring expiry, the hold at the terminal value and the restart/tick collision within a few dozen cycles. Counts are checked only while the timer is frozen or expired, so every expected value follows from the number of advancing clock edges between two control writes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BUS_W      = 32;
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_COUNT  = 'h08;
  localparam int OFS_RESTART = 'h0C;

  localparam int POS_RUN    = 18;
  localparam int POS_RSTEN  = 21;
  localparam int POS_CLKEN  = 24;
  localparam int POS_DIVEN  = 25;
  localparam int LIVE_SHIFT = 16;

  // Prescaler wraps when the next phase reaches the divide value; 0 acts as 1.
  function automatic logic presc_wrap(input logic [31:0] phase, input logic [31:0] div);
    logic [32:0] nxt;
    nxt = {1'b0, phase} + 33'd1;
    return nxt >= {1'b0, div};
  endfunction

  // Count may advance only while strictly below the terminal value.
  function automatic logic cnt_can_step(input logic [31:0] cnt, input logic [31:0] term);
    return cnt < term;
  endfunction

  // True when one more step lands exactly on the terminal value.
  function automatic logic cnt_hits_term(input logic [31:0] cnt, input logic [31:0] term);
    return ({1'b0, cnt} + 33'd1) == {1'b0, term};
  endfunction
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile #(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 18,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [wdt_pkg::BUS_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]          live_cnt,
  output logic [wdt_pkg::BUS_W-1:0] bus_rdata,
  output logic                      ctrl_en,
  output logic                      rst_en,
  output logic                      clk_en,
  output logic                      div_en,
  output logic [DIV_W-1:0]          div_val,
  output logic [CNT_W-1:0]          term,
  output logic                      restart_evt
);
  import wdt_pkg::*;

  logic sel_ctrl, sel_count, sel_restart;
  logic [BUS_W-1:0] ctrl_word, count_word;

  assign sel_ctrl    = bus_addr == ADDR_W'(OFS_CTRL);
  assign sel_count   = bus_addr == ADDR_W'(OFS_COUNT);
  assign sel_restart = bus_addr == ADDR_W'(OFS_RESTART);

  assign restart_evt = bus_wr && sel_restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      rst_en  <= 1'b0;
      clk_en  <= 1'b0;
      div_en  <= 1'b0;
      div_val <= '0;
    end else if (bus_wr && sel_ctrl) begin
      ctrl_en <= bus_wdata[POS_RUN];
      rst_en  <= bus_wdata[POS_RSTEN];
      clk_en  <= bus_wdata[POS_CLKEN];
      div_en  <= bus_wdata[POS_DIVEN];
      div_val <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) term <= '0;
    else if (bus_wr && sel_count) term <= bus_wdata[CNT_W-1:0];
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[DIV_W-1:0] = div_val;
    ctrl_word[POS_RUN]   = ctrl_en;
    ctrl_word[POS_RSTEN] = rst_en;
    ctrl_word[POS_CLKEN] = clk_en;
    ctrl_word[POS_DIVEN] = div_en;
  end

  always_comb begin
    count_word = '0;
    count_word[CNT_W-1:0] = term;
    count_word[LIVE_SHIFT +: CNT_W] = live_cnt;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ctrl)       bus_rdata = ctrl_word;
      else if (sel_count) bus_rdata = count_word;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] phase;

  assign tick = run && wdt_pkg::presc_wrap(32'(phase), 32'(div_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (!ctrl_en) phase <= '0;
    else if (run) begin
      if (tick) phase <= '0;
      else      phase <= phase + DIV_W'(1);
    end
  end
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             rst_en,
  input  logic             tick,
  input  logic             restart_evt,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt,
  output logic             expire_evt,
  output logic             rst_req
);
  logic step;

  assign step = ctrl_en && tick && !restart_evt &&
                wdt_pkg::cnt_can_step(32'(cnt), 32'(term));
  assign expire_evt = step && wdt_pkg::cnt_hits_term(32'(cnt), 32'(term));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (restart_evt) cnt <= '0;
    else if (step)        cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= expire_evt && rst_en;
  end
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 18,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_req
);
  logic             ctrl_en, rst_en, clk_en, div_en;
  logic [DIV_W-1:0] div_val;
  logic [CNT_W-1:0] term, cnt;
  logic             run, tick, restart_evt, expire_evt;

  assign run = ctrl_en && clk_en && div_en;

  wdt_regfile #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .live_cnt(cnt),
    .bus_rdata(bus_rdata), .ctrl_en(ctrl_en), .rst_en(rst_en),
    .clk_en(clk_en), .div_en(div_en), .div_val(div_val), .term(term),
    .restart_evt(restart_evt)
  );

  wdt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .run(run),
    .div_val(div_val), .tick(tick)
  );

  wdt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .rst_en(rst_en),
    .tick(tick), .restart_evt(restart_evt), .term(term), .cnt(cnt),
    .expire_evt(expire_evt), .rst_req(wdt_rst_req)
  );
endmodule

// File: rtl/tick_watchdog_checker.sv
module tick_watchdog_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdt_rst_req,
  input logic             run,
  input logic             tick,
  input logic             ctrl_en,
  input logic             rst_en,
  input logic             restart_evt,
  input logic [CNT_W-1:0] cnt
);
  // R3: ticks only while all three enables are set
  a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  // R3: the count moves by at most one per cycle unless cleared
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_evt |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

  // R4: a stopped timer keeps its count
  a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !restart_evt) |=> $stable(cnt));

  // R6: a restart write leaves the count at zero
  a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (cnt == '0));

  // R7: a reset request follows a tick taken while running
  a_r7_req_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> $past(tick && ctrl_en));

  // R8: no reset request unless reset-enable was set
  a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> $past(rst_en));
endmodule

bind tick_watchdog tick_watchdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_rst_req(wdt_rst_req), .run(run),
  .tick(tick), .ctrl_en(ctrl_en), .rst_en(rst_en),
  .restart_evt(restart_evt), .cnt(cnt)
);

// File: tb/tick_watchdog_test.sv
module tick_watchdog_test;
  localparam int ADDR_W = 8;
  localparam logic [31:0] RUN   = 32'h0004_0000;
  localparam logic [31:0] RSTEN = 32'h0020_0000;
  localparam logic [31:0] CLKEN = 32'h0100_0000;
  localparam logic [31:0] DIVEN = 32'h0200_0000;
  localparam logic [31:0] GATES = CLKEN | DIVEN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wdt_rst_req;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  tick_watchdog #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_req(wdt_rst_req)
  );

  function automatic logic [31:0] count_word(int live, int trm);
    return (32'(live) << 16) | (32'(trm) & 32'hFFFF);
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic read_expect(input int addr, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(addr);
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every strobed read
  initial forever begin
    item_t it;
    @(negedge clk);
    #1;
    if (bus_rd === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read with no expectation, got %h expected none", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        check(bus_rdata, it.exp, it.tag);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && wdt_rst_req === 1'b1) pulses++;
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(32'(wdt_rst_req), 32'd0, "R1 rst_req low after reset");
    read_expect('h00, 32'h0, "R1 control zero");
    read_expect('h08, 32'h0, "R1 count zero");
    read_expect('h0C, 32'h0, "R1 restart zero");

    // R2 only defined fields are stored
    bus_write('h00, 32'hFFFF_FFFF);
    read_expect('h00, 32'h0327_FFFF, "R2 stored field mask");
    bus_write('h00, 32'h0);
    bus_write('h0C, 32'h0);

    // R5 terminal is 16 bits, live half read-only
    bus_write('h08, 32'hFFFF_FFFF);
    read_expect('h08, 32'h0000_FFFF, "R5 terminal max, live half ignores write");

    // R3 rate: D=4, 40 advancing edges -> 10 ticks
    bus_write('h08, 32'd1000);
    bus_write('h00, RUN | GATES | 32'd4);
    idle(38);
    bus_write('h00, GATES | 32'd4);
    read_expect('h08, count_word(10, 1000), "R3 ten ticks at divide 4");
    idle(10);
    read_expect('h08, count_word(10, 1000), "R4 count holds while stopped");
    read_expect('h00, 32'h0300_0004, "R2 run cleared, other fields kept");

    // R5 terminal write keeps live count
    bus_write('h08, 32'd500);
    read_expect('h08, count_word(10, 500), "R5 terminal write keeps count");

    // R6 restart with arbitrary data
    bus_write('h0C, 32'hDEAD_BEEF);
    read_expect('h08, count_word(0, 500), "R6 restart clears count");
    read_expect('h0C, 32'h0, "R6 restart offset reads zero");

    // R4 phase rewinds on stop: two runs of 3 edges each at D=4
    bus_write('h00, RUN | GATES | 32'd4);
    idle(1);
    bus_write('h00, GATES | 32'd4);
    bus_write('h00, RUN | GATES | 32'd4);
    idle(1);
    bus_write('h00, GATES | 32'd4);
    read_expect('h08, count_word(0, 500), "R4 prescaler phase rewound");

    // R3 divider gate off: no ticks
    bus_write('h00, RUN | CLKEN | 32'd1);
    idle(20);
    bus_write('h00, 32'h0);
    read_expect('h08, count_word(0, 500), "R3 no ticks without divider enable");

    // R6 restart beats a tick at D=1: restart edge gives 0, then two more edges
    bus_write('h00, RUN | GATES | 32'd1);
    idle(5);
    bus_write('h0C, 32'h1);
    bus_write('h00, GATES | 32'd1);
    read_expect('h08, count_word(2, 500), "R6 restart wins over tick");

    // R7 expiry with reset enabled, D=0 acts as 1... use D=2, terminal 3
    bus_write('h0C, 32'h0);
    bus_write('h08, 32'd3);
    pulses = 0;
    bus_write('h00, RUN | RSTEN | GATES | 32'd2);
    idle(20);
    check(32'(pulses), 32'd1, "R7 exactly one reset pulse");
    read_expect('h08, count_word(3, 3), "R7 count holds at terminal");
    bus_write('h00, GATES | 32'd0);

    // R8 expiry with reset disabled, D=0 acts as 1
    bus_write('h0C, 32'h0);
    pulses = 0;
    bus_write('h00, RUN | GATES | 32'd0);
    idle(20);
    check(32'(pulses), 32'd0, "R8 no pulse without reset enable");
    read_expect('h08, count_word(3, 3), "R8 count stops at terminal");
    bus_write('h00, GATES | 32'd0);

    // R9 unmapped offset
    bus_write('h04, 32'hFFFF_FFFF);
    read_expect('h04, 32'h0, "R9 unmapped read zero");
    read_expect('h00, 32'h0300_0000, "R9 unmapped write ignored by control");
    read_expect('h08, count_word(3, 3), "R9 unmapped write ignored by count");

    idle(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d reads left, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule